// File: doc/BRIEF.md
# Device Reset Delay Timer

This block keeps the processor core in reset for a fixed number of slow RC ticks after any reset event. It counts only on cycles where the free-running RC tick input is high. It does not count on the main clock. The number of ticks it waits depends on two things: whether this is the first reset since power-up, and which oscillator mode is selected.

The reset events are the power-on reset, a low level on the external reset pin, a watchdog timeout and a pin-change wake-up. A watchdog timeout during sleep is treated like any other watchdog timeout, so it starts the delay again. The power-on reset is the block's asynchronous reset. The other events are sampled on the clock.

The first delay after power-up is always the long one. After that, a crystal-type mode keeps the long delay so the crystal has time to start. A mode with a ready-made clock uses the short delay.

Top module: `core_reset_delay`

## Requirements
- R1: While `por_i` is high, `core_hold_o` is high. After `por_i` falls, `core_hold_o` stays high until `LONG_TICKS` RC ticks have been seen. This holds for every value of `osc_mode_i`.
- R2: After the first delay has completed, a reset event with `osc_mode_i` at 3 (external clock), 4 (internal oscillator) or 5 (external RC) holds the core for `SHORT_TICKS` ticks.
- R3: After the first delay has completed, a reset event with `osc_mode_i` at 0 (low-power crystal), 1 (crystal), 2 (high-speed crystal/resonator), 6 or 7 holds the core for `LONG_TICKS` ticks.
- R4: A watchdog timeout, a pin wake pulse or a low reset pin in one cycle makes `core_hold_o` high in the next cycle.
- R5: While `ext_rst_n_i` is low, `core_hold_o` stays high and ticks are not counted. The delay counts only from the first cycle in which the pin is high again.
- R6: A reset event that arrives while a delay is running restarts the count from zero. This is true even in the cycle where a tick would have ended the delay.
- R7: A cycle without an RC tick never advances the delay. `core_hold_o` falls only on a cycle in which a tick is present.
- R8: A reset event during the first delay after power-up still gets the long delay. The power-up state is cleared only when a delay runs to completion.
- R9: The oscillator mode is taken in the cycle of the reset event. Changing `osc_mode_i` while the delay is running does not change the delay's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin level, low means reset |
| wdt_timeout_i | input | 1 | Watchdog timeout event, one cycle |
| pin_wake_i | input | 1 | Pin-change wake event, one cycle |
| rc_tick_i | input | 1 | Enable pulse from the internal RC clock |
| osc_mode_i | input | 3 | Oscillator mode select |
| core_hold_o | output | 1 | Core held in reset while high |

## Verification
Two things can happen in the same cycle: the tick that would end a delay, and a new reset event. The bench provokes this deliberately. It drives `LONG_TICKS-1` ticks and then, in one cycle, a final tick together with a watchdog timeout. It then requires `core_hold_o` to stay high and a complete new delay to follow. A bound check of delay lengths catches a delay that ends one tick early because the completion won over the restart. Random rounds also place events on cycles where a tick is present.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  typedef enum logic [2:0] {
    OSC_LP_XTAL  = 3'd0,
    OSC_XTAL     = 3'd1,
    OSC_HS_XTAL  = 3'd2,
    OSC_EXT_CLK  = 3'd3,
    OSC_INT_RC   = 3'd4,
    OSC_EXT_RC   = 3'd5,
    OSC_RSVD6    = 3'd6,
    OSC_RSVD7    = 3'd7
  } osc_mode_e;

  // A short delay is allowed only once power-up is over and the clock
  // source needs no start-up time.
  function automatic logic short_delay_ok(input logic first_pwr,
                                          input logic [2:0] mode);
    logic quick_src;
    quick_src = (mode == OSC_EXT_CLK) || (mode == OSC_INT_RC) ||
                (mode == OSC_EXT_RC);
    return quick_src && !first_pwr;
  endfunction

endpackage

// File: rtl/rdt_evt_merge.sv
module rdt_evt_merge (
  input  logic ext_rst_n_i,
  input  logic wdt_timeout_i,
  input  logic pin_wake_i,
  output logic restart_o
);
  // The pin holds the restart for as long as it is low, so counting
  // begins only after it is released.
  always_comb restart_o = !ext_rst_n_i || wdt_timeout_i || pin_wake_i;
endmodule

// File: rtl/rdt_pwr_flag.sv
module rdt_pwr_flag (
  input  logic clk,
  input  logic por_i,
  input  logic done_i,
  output logic first_o
);
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)       first_o <= 1'b1;
    else if (done_i) first_o <= 1'b0;
  end
endmodule

// File: rtl/rdt_len_sel.sv
module rdt_len_sel
  import rdt_pkg::*;
#(
  parameter int LONG_TICKS  = 576,
  parameter int SHORT_TICKS = 2,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             restart_i,
  input  logic             first_i,
  input  logic [2:0]       mode_i,
  output logic [CNT_W-1:0] target_o
);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_TICKS);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_TICKS);

  logic [CNT_W-1:0] pick;
  always_comb pick = short_delay_ok(first_i, mode_i) ? SHORT_V : LONG_V;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          target_o <= LONG_V;
    else if (restart_i) target_o <= pick;
  end
endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic last_tick;
  always_comb last_tick = (cnt_o == target_i - 1'b1);
  always_comb done_o    = active_o && !restart_i && tick_i && last_tick;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
    end else if (restart_i) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
    end else if (done_o) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
    end else if (active_o && tick_i) begin
      cnt_o    <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/core_reset_delay.sv
module core_reset_delay #(
  parameter int LONG_TICKS  = 576,
  parameter int SHORT_TICKS = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       ext_rst_n_i,
  input  logic       wdt_timeout_i,
  input  logic       pin_wake_i,
  input  logic       rc_tick_i,
  input  logic [2:0] osc_mode_i,
  output logic       core_hold_o
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic             restart_evt;
  logic             delay_done;
  logic             first_q;
  logic             active_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] cnt_q;

  rdt_evt_merge u_evt (
    .ext_rst_n_i  (ext_rst_n_i),
    .wdt_timeout_i(wdt_timeout_i),
    .pin_wake_i   (pin_wake_i),
    .restart_o    (restart_evt)
  );

  rdt_pwr_flag u_flag (
    .clk    (clk),
    .por_i  (por_i),
    .done_i (delay_done),
    .first_o(first_q)
  );

  rdt_len_sel #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .CNT_W      (CNT_W)
  ) u_len (
    .clk      (clk),
    .por_i    (por_i),
    .restart_i(restart_evt),
    .first_i  (first_q),
    .mode_i   (osc_mode_i),
    .target_o (target_q)
  );

  rdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .por_i    (por_i),
    .restart_i(restart_evt),
    .tick_i   (rc_tick_i),
    .target_i (target_q),
    .active_o (active_q),
    .cnt_o    (cnt_q),
    .done_o   (delay_done)
  );

  always_comb core_hold_o = active_q;
endmodule

// File: rtl/core_reset_delay_chk.sv
module core_reset_delay_chk #(
  parameter int LONG_TICKS  = 576,
  parameter int SHORT_TICKS = 2,
  parameter int CNT_W       = 10
) (
  input logic             clk,
  input logic             por_i,
  input logic             ext_rst_n_i,
  input logic             rc_tick_i,
  input logic             restart,
  input logic             first,
  input logic [CNT_W-1:0] cnt,
  input logic             hold
);
  int unsigned seen;
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                  seen <= 0;
    else if (restart)           seen <= 0;
    else if (hold && rc_tick_i) seen <= seen + 1;
  end

  // R1
  first_len_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(first) |-> (seen == LONG_TICKS));
  // R2
  any_len_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(hold) |-> (seen == LONG_TICKS || seen == SHORT_TICKS));
  // R4
  evt_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    restart |=> hold);
  // R5
  pin_low_chk: assert property (@(posedge clk) disable iff (por_i)
    !ext_rst_n_i |=> (hold && cnt == '0));
  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (por_i)
    restart |=> (cnt == '0));
  // R7
  no_tick_chk: assert property (@(posedge clk) disable iff (por_i)
    (hold && !rc_tick_i && !restart) |=> hold);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(first) |-> $fell(hold));
endmodule

bind core_reset_delay core_reset_delay_chk #(
  .LONG_TICKS (LONG_TICKS),
  .SHORT_TICKS(SHORT_TICKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .ext_rst_n_i(ext_rst_n_i),
  .rc_tick_i  (rc_tick_i),
  .restart    (restart_evt),
  .first      (first_q),
  .cnt        (cnt_q),
  .hold       (core_hold_o)
);

// File: tb/core_reset_delay_tb.sv
`timescale 1ns/1ps
module core_reset_delay_tb;
  localparam int LONG  = 20;
  localparam int SHORT = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       por = 1'b1, pin_n = 1'b1, wdt = 1'b0, wake = 1'b0, tick = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       hold;
  int total = 0, bad = 0;
  bit first_m = 1'b1;
  bit finished = 1'b0;

  core_reset_delay #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u_dut (
    .clk(clk), .por_i(por), .ext_rst_n_i(pin_n), .wdt_timeout_i(wdt),
    .pin_wake_i(wake), .rc_tick_i(tick), .osc_mode_i(mode),
    .core_hold_o(hold)
  );

  // Expected hold length: short only after power-up, in modes 3, 4, 5.
  function automatic int exp_len(bit f, logic [2:0] m);
    if (!f && (m == 3'd3 || m == 3'd4 || m == 3'd5)) return SHORT;
    return LONG;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(int kind);
    @(negedge clk);
    case (kind)
      0: wdt = 1'b1;
      1: wake = 1'b1;
      default: pin_n = 1'b0;
    endcase
    tick = 1'($urandom % 2);
    @(negedge clk);
    wdt = 1'b0; wake = 1'b0; pin_n = 1'b1; tick = 1'b0;
    check(hold == 1'b1, "R4", int'(hold), 1);
  endtask

  task automatic measure(output int n);
    int cyc = 0;
    n = 0;
    while (hold && cyc < 5000) begin
      tick = ($urandom % 3 == 0);
      if (tick) n++;
      @(negedge clk);
      cyc++;
    end
    tick = 1'b0;
  endtask

  task automatic run_case(int kind, logic [2:0] m, string req);
    int n, e;
    mode = m;
    e = exp_len(first_m, m);
    fire(kind);
    measure(n);
    check(n == e, req, n, e);
    first_m = 1'b0;
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int n;
    bit ok;
    void'($urandom(32'd1234));
    // R1: reset state and first delay
    mode = 3'd4;
    repeat (3) @(negedge clk);
    check(hold == 1'b1, "R1", int'(hold), 1);
    por = 1'b0;
    measure(n);
    check(n == LONG, "R1", n, LONG);
    first_m = 1'b0;

    // R2 / R3 over every mode
    for (int m = 0; m < 8; m++) begin
      run_case(m % 2, 3'(m), (m >= 3 && m <= 5) ? "R2" : "R3");
    end

    // R5: pin held low while ticks run
    mode = 3'd4;
    @(negedge clk);
    pin_n = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (!hold) ok = 1'b0;
    end
    check(ok, "R5", int'(ok), 1);
    pin_n = 1'b1; tick = 1'b0;
    measure(n);
    check(n == SHORT, "R5", n, SHORT);

    // R6: restart mid-delay
    mode = 3'd0;
    fire(0);
    ticks(10);
    check(hold == 1'b1, "R6", int'(hold), 1);
    fire(1);
    measure(n);
    check(n == LONG, "R6", n, LONG);

    // R6: final tick and watchdog in the same cycle
    fire(0);
    ticks(LONG - 1);
    tick = 1'b1; wdt = 1'b1;
    @(negedge clk);
    tick = 1'b0; wdt = 1'b0;
    check(hold == 1'b1, "R6", int'(hold), 1);
    measure(n);
    check(n == LONG, "R6", n, LONG);

    // R7: no ticks, no progress
    fire(0);
    repeat (50) @(negedge clk);
    check(hold == 1'b1, "R7", int'(hold), 1);
    measure(n);
    check(n == LONG, "R7", n, LONG);

    // R8: event during first delay after a new power-on
    @(negedge clk);
    por = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0;
    first_m = 1'b1;
    ticks(5);
    run_case(1, 3'd4, "R8");
    run_case(0, 3'd4, "R8");

    // R9: mode change during delay
    mode = 3'd4;
    fire(0);
    mode = 3'd0;
    measure(n);
    check(n == SHORT, "R9", n, SHORT);
    mode = 3'd5;
    fire(1);
    mode = 3'd2;
    measure(n);
    check(n == SHORT, "R9", n, SHORT);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int k;
      logic [2:0] m;
      k = int'($urandom % 3);
      m = 3'($urandom % 8);
      run_case(k, m, (m >= 3 && m <= 5) ? "R2" : "R3");
    end

    summary();
  end
endmodule